// File: doc/BRIEF.md
# Dual-Channel Over-Scale Flag Generator

This block sits after the decimation filters of a two-channel converter and watches the left and right sample streams at the frame rate. Each frame strobe delivers one 18-bit two's-complement sample per channel. With it come two range indicators per channel from the filter, one for above range and one for below range. The block registers a clamped copy of each sample. While a channel is out of range, its output is pinned to the matching full-scale code.

Each channel also has a persistent over-scale flag. The flag rises only after two back-to-back out-of-range conversions on that channel. Once raised, it stays high for a fixed window of 4096 frame strobes and then drops. Another qualifying pair of conversions inside the window starts the window again from the beginning. An active-high digital power-down input forces the flags and outputs low and clears the conversion history. The two channels share the strobe and the power-down input but are otherwise fully independent.

Top module: `ovs_monitor`

## Requirements
- R1: A channel's flag rises on the clock edge of a strobe where that channel is out of range (above-range or below-range indicator high) and was also out of range on its previous strobe. A single out-of-range strobe, or two separated by an in-range strobe, leaves the flag low.
- R2: After the raising strobe, the flag stays high through the next 4095 strobes and falls on the edge of the 4096th strobe, if no new trigger occurs. Cycles without a strobe never change the flag.
- R3: A trigger while the flag is high reloads the window, so the flag stays high for a further 4096 strobes counted from the new trigger. A third or later consecutive out-of-range strobe counts as a trigger.
- R4: While power-down is high, both flags and both sample outputs go to 0 on the next edge. The out-of-range history is cleared, so one out-of-range strobe before power-down and one after it do not raise a flag.
- R5: On a strobe with the above-range indicator high, the channel output becomes 0x1FFFF. The above-range indicator wins when both indicators are high.
- R6: On a strobe with only the below-range indicator high, the channel output becomes 0x20000.
- R7: On an in-range strobe the channel output takes the input sample one clock edge later. Without a strobe the output holds.
- R8: The left and right channels have independent history, flag windows and outputs.
- R9: Synchronous active-high reset clears both flags and both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Digital power-down, active high |
| frame_stb | input | 1 | One-cycle strobe marking a new conversion pair |
| smp_l | input | 18 | Left sample, two's complement |
| smp_r | input | 18 | Right sample, two's complement |
| above_l | input | 1 | Left input above full range |
| below_l | input | 1 | Left input below full range |
| above_r | input | 1 | Right input above full range |
| below_r | input | 1 | Right input below full range |
| flag_l | output | 1 | Left over-scale flag |
| flag_r | output | 1 | Right over-scale flag |
| out_l | output | 18 | Left clamped sample |
| out_r | output | 18 | Right clamped sample |

## Verification
Two functions can meet in one strobe: a new trigger can arrive when the hold window has one strobe left, and power-down can come on the same cycle as a strobe that would otherwise trigger. The first case is provoked by placing an out-of-range pair so that its second strobe is the last strobe of the window. The flag must then stay high for a full new window instead of dropping. The second case drives power-down together with an out-of-range strobe, and power-down must win for flag, output and history. A bench model that follows the requirements is compared on every cycle, both in these directed runs and in a seeded random stream with both channels mixed.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  typedef enum logic [1:0] {
    RNG_OK   = 2'd0,
    RNG_HIGH = 2'd1,
    RNG_LOW  = 2'd2
  } rng_e;

  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/ovs_clamp.sv
module ovs_clamp #(
  parameter int unsigned DATA_W = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pd,
  input  logic               stb,
  input  logic [DATA_W-1:0]  smp,
  input  ovs_pkg::rng_e      rng,
  output logic [DATA_W-1:0]  dout
);
  import ovs_pkg::*;

  localparam logic [DATA_W-1:0] POS_FS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] sel;

  always_comb begin
    unique case (rng)
      RNG_HIGH: sel = POS_FS;
      RNG_LOW:  sel = NEG_FS;
      default:  sel = smp;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || pd)      dout <= '0;
    else if (stb)       dout <= sel;
  end

  a_r5_pos_clamp: assert property (@(posedge clk) disable iff (rst)
    (stb && !pd && rng == RNG_HIGH) |=> (dout == POS_FS));
  a_r6_neg_clamp: assert property (@(posedge clk) disable iff (rst)
    (stb && !pd && rng == RNG_LOW) |=> (dout == NEG_FS));
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!stb && !pd) |=> $stable(dout));
  a_r4_out_zero: assert property (@(posedge clk) disable iff (rst)
    pd |=> (dout == '0));
endmodule

// File: rtl/ovs_run_det.sv
module ovs_run_det #(
  parameter int unsigned RUN_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pd,
  input  logic stb,
  input  logic over,
  output logic trig
);
  localparam int unsigned RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] RUN_SAT = RW'(RUN_LEN - 1);

  logic [RW-1:0] run;

  assign trig = stb && over && (run == RUN_SAT);

  always_ff @(posedge clk) begin
    if (rst || pd)        run <= '0;
    else if (stb) begin
      if (!over)          run <= '0;
      else if (run != RUN_SAT) run <= run + 1'b1;
    end
  end

  a_r1_inrange_breaks: assert property (@(posedge clk) disable iff (rst)
    (stb && !over && !pd) |=> !trig);
  a_r4_pd_breaks: assert property (@(posedge clk) disable iff (rst)
    pd |=> !trig);
endmodule

// File: rtl/ovs_hold_timer.sv
module ovs_hold_timer #(
  parameter int unsigned HOLD_FRAMES = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic pd,
  input  logic stb,
  input  logic trig,
  output logic flag
);
  localparam int unsigned CW = $clog2(HOLD_FRAMES + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_FRAMES);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (stb) begin
      if (trig)           cnt_nxt = LOAD;
      else if (cnt != '0) cnt_nxt = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || pd) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      flag <= (cnt_nxt != '0);
    end
  end

  a_r4_flag_pd: assert property (@(posedge clk) disable iff (rst)
    pd |=> !flag);
  a_r1_trig_raises: assert property (@(posedge clk) disable iff (rst)
    (stb && trig && !pd) |=> flag);
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!stb && !pd) |=> $stable(flag));
  a_r2_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(stb || pd));
endmodule

// File: rtl/ovs_monitor.sv
module ovs_monitor #(
  parameter int unsigned DATA_W      = 18,
  parameter int unsigned HOLD_FRAMES = 4096,
  parameter int unsigned RUN_LEN     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_dn,
  input  logic              frame_stb,
  input  logic [DATA_W-1:0] smp_l,
  input  logic [DATA_W-1:0] smp_r,
  input  logic              above_l,
  input  logic              below_l,
  input  logic              above_r,
  input  logic              below_r,
  output logic              flag_l,
  output logic              flag_r,
  output logic [DATA_W-1:0] out_l,
  output logic [DATA_W-1:0] out_r
);
  import ovs_pkg::*;

  logic [DATA_W-1:0] smp_a  [NUM_CH];
  logic [DATA_W-1:0] out_a  [NUM_CH];
  logic              hi_a   [NUM_CH];
  logic              lo_a   [NUM_CH];
  logic              flag_a [NUM_CH];

  assign smp_a[0] = smp_l;
  assign smp_a[1] = smp_r;
  assign hi_a[0]  = above_l;
  assign hi_a[1]  = above_r;
  assign lo_a[0]  = below_l;
  assign lo_a[1]  = below_r;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    rng_e rng;
    logic trig;

    always_comb begin
      if (hi_a[c])      rng = RNG_HIGH;
      else if (lo_a[c]) rng = RNG_LOW;
      else              rng = RNG_OK;
    end

    ovs_clamp #(.DATA_W(DATA_W)) u_clamp (
      .clk(clk), .rst(rst), .pd(pwr_dn), .stb(frame_stb),
      .smp(smp_a[c]), .rng(rng), .dout(out_a[c])
    );

    ovs_run_det #(.RUN_LEN(RUN_LEN)) u_run (
      .clk(clk), .rst(rst), .pd(pwr_dn), .stb(frame_stb),
      .over(rng != RNG_OK), .trig(trig)
    );

    ovs_hold_timer #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
      .clk(clk), .rst(rst), .pd(pwr_dn), .stb(frame_stb),
      .trig(trig), .flag(flag_a[c])
    );
  end

  assign flag_l = flag_a[0];
  assign flag_r = flag_a[1];
  assign out_l  = out_a[0];
  assign out_r  = out_a[1];

  a_r9_reset_flags: assert property (@(posedge clk)
    rst |=> (!flag_l && !flag_r && out_l == '0 && out_r == '0));
endmodule

// File: tb/ovs_monitor_tb.sv
module ovs_monitor_tb;
  localparam int HOLD = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_dn = 1'b0, frame_stb = 1'b0;
  logic [17:0] smp_l = '0, smp_r = '0;
  logic        above_l = 1'b0, below_l = 1'b0, above_r = 1'b0, below_r = 1'b0;
  logic        flag_l, flag_r;
  logic [17:0] out_l, out_r;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  bit          m_prev [2];
  int          m_cnt  [2];
  logic [17:0] m_out  [2];

  always #2 clk = ~clk;

  ovs_monitor u_dut (
    .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .frame_stb(frame_stb),
    .smp_l(smp_l), .smp_r(smp_r), .above_l(above_l), .below_l(below_l),
    .above_r(above_r), .below_r(below_r),
    .flag_l(flag_l), .flag_r(flag_r), .out_l(out_l), .out_r(out_r)
  );

  function automatic logic [17:0] exp_clamp(logic [17:0] s, logic hi, logic lo);
    if (hi) return 18'h1FFFF;
    if (lo) return 18'h20000;
    return s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic model_upd(int c, logic stb, logic pd, logic [17:0] s, logic hi, logic lo);
    bit over, trg;
    if (pd) begin
      m_prev[c] = 1'b0; m_cnt[c] = 0; m_out[c] = '0;
    end else if (stb) begin
      over = hi | lo;
      trg  = over && m_prev[c];
      m_prev[c] = over;
      if (trg) m_cnt[c] = HOLD;
      else if (m_cnt[c] != 0) m_cnt[c]--;
      m_out[c] = exp_clamp(s, hi, lo);
    end
  endtask

  task automatic step(logic stb, logic pd, logic [17:0] sl, logic hl, logic ll,
                      logic [17:0] sr, logic hr, logic lr, string tag);
    @(negedge clk);
    frame_stb = stb; pwr_dn = pd;
    smp_l = sl; above_l = hl; below_l = ll;
    smp_r = sr; above_r = hr; below_r = lr;
    model_upd(0, stb, pd, sl, hl, ll);
    model_upd(1, stb, pd, sr, hr, lr);
    @(posedge clk); #1;
    chk({tag, " flag_l"}, 32'(flag_l), 32'(m_cnt[0] != 0));
    chk({tag, " flag_r"}, 32'(flag_r), 32'(m_cnt[1] != 0));
    chk({tag, " out_l"},  32'(out_l),  32'(m_out[0]));
    chk({tag, " out_r"},  32'(out_r),  32'(m_out[1]));
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 18'h0, 1'b0, 1'b0, 18'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic ok_strobes(int n, string tag);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, 18'h00111, 1'b0, 1'b0, 18'h3FFF0, 1'b0, 1'b0, tag);
      if (i % 7 == 0) idle(1, tag);
    end
  endtask

  task automatic print_summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      print_summary();
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin m_prev[c] = 0; m_cnt[c] = 0; m_out[c] = '0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset flag_l", 32'(flag_l), 0);
    chk("R9 reset flag_r", 32'(flag_r), 0);
    chk("R9 reset out_l", 32'(out_l), 0);
    chk("R9 reset out_r", 32'(out_r), 0);
    @(negedge clk); rst = 1'b0;

    // R7: pass-through and hold without strobe
    step(1'b1, 1'b0, 18'h12345, 0, 0, 18'h00ABC, 0, 0, "R7 pass");
    chk("R7 out_l pass", 32'(out_l), 32'h12345);
    step(1'b0, 1'b0, 18'h2AAAA, 1, 0, 18'h15555, 0, 1, "R7 idle");
    chk("R7 out_l hold", 32'(out_l), 32'h12345);
    chk("R7 out_r hold", 32'(out_r), 32'h00ABC);

    // R5, R1 single and separated overs
    step(1'b1, 1'b0, 18'h00005, 1, 0, 18'h00001, 0, 0, "R5 hi");
    chk("R5 out_l full-scale", 32'(out_l), 32'h1FFFF);
    chk("R1 single no flag", 32'(flag_l), 0);
    step(1'b1, 1'b0, 18'h00006, 0, 0, 18'h00001, 0, 0, "R1 break");
    step(1'b1, 1'b0, 18'h00007, 1, 1, 18'h00001, 0, 0, "R5 both");
    chk("R5 hi wins", 32'(out_l), 32'h1FFFF);
    chk("R1 separated no flag", 32'(flag_l), 0);
    idle(2, "R2 idle");
    step(1'b1, 1'b0, 18'h00008, 1, 0, 18'h00002, 0, 1, "R1 pair");
    chk("R1 pair raises flag_l", 32'(flag_l), 1);
    chk("R8 flag_r independent", 32'(flag_r), 0);
    chk("R6 out_r neg clamp", 32'(out_r), 32'h20000);

    // R2 exact window on left
    ok_strobes(HOLD - 1, "R2 window");
    chk("R2 flag_l high at 4095", 32'(flag_l), 1);
    idle(3, "R2 idle");
    chk("R2 flag_l idle hold", 32'(flag_l), 1);
    ok_strobes(1, "R2 end");
    chk("R2 flag_l low at 4096", 32'(flag_l), 0);

    // R3 retrigger on the last strobe of the window (right channel)
    step(1'b1, 1'b0, 18'h0, 0, 0, 18'h0, 0, 1, "R3 a");
    step(1'b1, 1'b0, 18'h0, 0, 0, 18'h0, 0, 1, "R3 b");
    chk("R3 flag_r raised", 32'(flag_r), 1);
    ok_strobes(HOLD - 2, "R3 run");
    step(1'b1, 1'b0, 18'h0, 0, 0, 18'h0, 1, 0, "R3 c");
    step(1'b1, 1'b0, 18'h0, 0, 0, 18'h0, 1, 0, "R3 d");
    chk("R3 flag_r reloaded", 32'(flag_r), 1);
    ok_strobes(HOLD - 1, "R3 new window");
    chk("R3 flag_r still high", 32'(flag_r), 1);
    ok_strobes(1, "R3 end");
    chk("R3 flag_r low", 32'(flag_r), 0);

    // R4 power-down with strobe, history clear
    step(1'b1, 1'b0, 18'h0, 1, 0, 18'h0, 1, 0, "R4 a");
    step(1'b1, 1'b0, 18'h0, 1, 0, 18'h0, 1, 0, "R4 b");
    step(1'b1, 1'b1, 18'h0, 1, 0, 18'h0, 1, 0, "R4 pd");
    chk("R4 flag_l pd", 32'(flag_l), 0);
    chk("R4 out_l pd", 32'(out_l), 0);
    step(1'b1, 1'b0, 18'h0, 0, 1, 18'h0, 1, 0, "R4 after");
    chk("R4 history cleared", 32'(flag_l), 0);
    step(1'b1, 1'b1, 18'h0, 0, 0, 18'h0, 0, 0, "R4 pd2");

    // R8 seeded random mix
    void'($urandom(32'h5EED));
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      r = $urandom();
      step(r[0] | r[1], (r[15:8] == 8'h00),
           18'($urandom()), (r[4:2] == 3'd0), (r[7:5] == 3'd0),
           18'($urandom()), (r[18:16] == 3'd0), (r[21:19] == 3'd1),
           "R8 random");
    end

    done = 1'b1;
    print_summary();
    $finish;
  end
endmodule